// File: doc/BRIEF.md
# Guarded-Accumulator Add/Subtract with Selectable Condition Flag

This block is one slice of a DSP accumulator datapath. The datapath is 40 bits wide: an 8-bit guard field sits above a 32-bit main word. The block adds or subtracts two 40-bit operands and always works at the full width. A single registered condition flag reports one property of the result. A 3-bit condition-select code, presented in the same cycle as the operation, picks that property.

The flag can report one of six properties:
- the carry, or the borrow when subtracting;
- the sign;
- an all-zero result;
- overflow of the 32-bit main word;
- a strictly positive result;
- a non-negative result.

Overflow ignores the guard field, so it is judged as if the guard bits did not exist. As a result, a value that reaches into the guard field always counts as an overflow. The flag changes only on a clock edge where the update strobe is high. The sum or difference itself comes out combinationally.

Top module: `dsp_cond_flag`

## Requirements
- R1: `result` equals `op_a + op_b` modulo 2^40 when `op_sub` is 0, and equals `op_a - op_b` modulo 2^40 when `op_sub` is 1. It is combinational from the inputs.
- R2: Code 3'b000 captures the carry out of bit 39 for an add. For a subtract it captures the inverse of the carry out of `op_a + ~op_b + 1`, which is the borrow.
- R3: Code 3'b001 captures bit 39 of the result, the sign bit.
- R4: Code 3'b010 captures 1 when all 40 result bits are zero, and 0 otherwise.
- R5: Code 3'b011 captures 1 unless result bits 39 down to 31 are either all ones or all zeros. For example, guard 8'hFF with bit 31 = 0 gives 1, and guard 8'hFF with bit 31 = 1 gives 0.
- R6: Code 3'b100 captures 1 when bit 39 is 0 and the result is nonzero.
- R7: Code 3'b101 captures the inverse of bit 39.
- R8: Codes 3'b110 and 3'b111 leave `cond_flag` unchanged, even when `upd_en` is high.
- R9: `cond_flag` changes only on a rising clock edge where `upd_en` is high. With `upd_en` low it holds its value.
- R10: `cond_flag` is 0 while `rst_n` is low. The reset is asserted asynchronously. It is released through a two-stage synchronizer, so the first update can take effect at the third rising edge after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 40 | First operand |
| op_b | input | 40 | Second operand |
| op_sub | input | 1 | 0 = add, 1 = subtract |
| cond_sel | input | 3 | Condition-select code |
| upd_en | input | 1 | Flag update strobe |
| result | output | 40 | Sum or difference |
| cond_flag | output | 1 | Registered condition flag |

## Verification
The flag register is the only state in this block. A wrong flag therefore shows at `cond_flag` one cycle after the update that produced it, and it stays there until the next valid update. A wrong code decode or a wrong overflow slice therefore shows one cycle later, on the first operand pair whose properties differ between the correct and the faulty code. Directed cases cover the values around the guard/main-word boundary, for example 40'hFF_7FFF_FFFF against 40'hFF_8000_0000. Cases with a held strobe or a reserved code expose a register that updates when it should not. A reset synchronizer with the wrong depth shows as a flag update that lands one edge early or one edge late.

// File: rtl/dsp_cond_pkg.sv
package dsp_cond_pkg;
  typedef enum logic [2:0] {
    CS_CARRY = 3'b000,
    CS_NEG   = 3'b001,
    CS_ZERO  = 3'b010,
    CS_OVF   = 3'b011,
    CS_GT    = 3'b100,
    CS_GE    = 3'b101,
    CS_RSV6  = 3'b110,
    CS_RSV7  = 3'b111
  } cond_sel_e;
endpackage

// File: rtl/dsp_rst_sync.sv
module dsp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dsp_addsub.sv
module dsp_addsub #(
  parameter int ACC_W = 40
) (
  input  logic [ACC_W-1:0] a,
  input  logic [ACC_W-1:0] b,
  input  logic             sub,
  output logic [ACC_W-1:0] sum,
  output logic             cb_out
);
  logic [ACC_W-1:0] b_eff;
  logic [ACC_W:0]   wide;

  always_comb begin
    b_eff  = sub ? ~b : b;
    wide   = {1'b0, a} + {1'b0, b_eff} + {{ACC_W{1'b0}}, sub};
    sum    = wide[ACC_W-1:0];
    // borrow reported as inverted carry when subtracting
    cb_out = sub ? ~wide[ACC_W] : wide[ACC_W];
  end
endmodule

// File: rtl/dsp_cond_eval.sv
module dsp_cond_eval
  import dsp_cond_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int MAIN_W  = 32
) (
  input  logic [GUARD_W+MAIN_W-1:0] res,
  input  logic                      cb,
  input  cond_sel_e                 sel,
  output logic                      flag_val,
  output logic                      sel_valid
);
  localparam int ACC_W = GUARD_W + MAIN_W;
  localparam int OVF_W = GUARD_W + 1;

  logic [OVF_W-1:0] ovf_field;
  logic             is_zero;
  logic             is_neg;
  logic             is_ovf;

  always_comb begin
    ovf_field = res[ACC_W-1:MAIN_W-1];
    is_zero   = (res == '0);
    is_neg    = res[ACC_W-1];
    is_ovf    = !((&ovf_field) || (~|ovf_field));
    flag_val  = 1'b0;
    sel_valid = 1'b1;
    case (sel)
      CS_CARRY: flag_val = cb;
      CS_NEG:   flag_val = is_neg;
      CS_ZERO:  flag_val = is_zero;
      CS_OVF:   flag_val = is_ovf;
      CS_GT:    flag_val = !is_neg && !is_zero;
      CS_GE:    flag_val = !is_neg;
      default:  sel_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/dsp_cond_flag.sv
module dsp_cond_flag
  import dsp_cond_pkg::*;
#(
  parameter int GUARD_W = 8,
  parameter int MAIN_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [GUARD_W+MAIN_W-1:0] op_a,
  input  logic [GUARD_W+MAIN_W-1:0] op_b,
  input  logic                      op_sub,
  input  logic [2:0]                cond_sel,
  input  logic                      upd_en,
  output logic [GUARD_W+MAIN_W-1:0] result,
  output logic                      cond_flag
);
  localparam int ACC_W = GUARD_W + MAIN_W;

  logic      rst_sync_n;
  logic      cb;
  logic      flag_val;
  logic      sel_valid;
  logic      flag_q;
  logic      flag_d;
  logic      flag_en;
  cond_sel_e sel_e;

  assign sel_e = cond_sel_e'(cond_sel);

  dsp_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  dsp_addsub #(.ACC_W(ACC_W)) u_alu (
    .a(op_a), .b(op_b), .sub(op_sub), .sum(result), .cb_out(cb)
  );

  dsp_cond_eval #(.GUARD_W(GUARD_W), .MAIN_W(MAIN_W)) u_eval (
    .res(result), .cb(cb), .sel(sel_e),
    .flag_val(flag_val), .sel_valid(sel_valid)
  );

  always_comb begin
    flag_en = upd_en && sel_valid;
    flag_d  = flag_en ? flag_val : flag_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) flag_q <= 1'b0;
    else             flag_q <= flag_d;
  end

  assign cond_flag = flag_q;

  // R3
  neg_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && cond_sel == 3'b001) |=> (cond_flag == $past(result[ACC_W-1])));

  // R4
  zero_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && cond_sel == 3'b010) |=> (cond_flag == ($past(result) == '0)));

  // R5
  ovf_mode_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (upd_en && cond_sel == 3'b011 && result[ACC_W-1:MAIN_W-1] == '1) |=> !cond_flag);

  // R8
  rsv_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cond_sel[2:1] == 2'b11) |=> $stable(cond_flag));

  // R9
  no_upd_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !upd_en |=> $stable(cond_flag));
endmodule

// File: tb/dsp_cond_flag_tb.sv
module dsp_cond_flag_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 40;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic         op_sub;
  logic [2:0]   cond_sel;
  logic         upd_en;
  logic [W-1:0] result;
  logic         cond_flag;

  int n_chk;
  int n_fail;
  logic model_flag;

  dsp_cond_flag dut_i (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sub(op_sub),
    .cond_sel(cond_sel), .upd_en(upd_en), .result(result), .cond_flag(cond_flag)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    return s ? (a - b) : (a + b);
  endfunction

  function automatic logic ref_cb(input logic [W-1:0] a, input logic [W-1:0] b, input logic s);
    logic [W:0] t;
    if (s) return (b > a);             // borrow when b exceeds a
    t = {1'b0, a} + {1'b0, b};
    return t[W];
  endfunction

  function automatic logic ref_flag(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic s, input logic [2:0] c, input logic old);
    logic [W-1:0] r;
    r = ref_res(a, b, s);
    case (c)
      3'd0: return ref_cb(a, b, s);
      3'd1: return r[39];
      3'd2: return r == 0;
      3'd3: return !($signed(r) >= -40'sd2147483648 && $signed(r) <= 40'sd2147483647);
      3'd4: return $signed(r) > 0;
      3'd5: return $signed(r) >= 0;
      default: return old;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic s, input logic [2:0] c, input logic u);
    @(negedge clk);
    op_a = a; op_b = b; op_sub = s; cond_sel = c; upd_en = u;
    #1;
    check("R1", result, ref_res(a, b, s));
    if (u) model_flag = ref_flag(a, b, s, c, model_flag);
    @(negedge clk);
    check(req, {39'd0, cond_flag}, {39'd0, model_flag});
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; model_flag = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_a = '1; op_b = 40'd1; op_sub = 1'b0; cond_sel = 3'd0; upd_en = 1'b1;
    #(CLK_P * 3 + 2);
    check("R10", {39'd0, cond_flag}, 40'd0);
    // R10: release at a negedge, hold upd_en high with a carry-producing add
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); check("R10", {39'd0, cond_flag}, 40'd0);
    @(negedge clk); check("R10", {39'd0, cond_flag}, 40'd0);
    @(negedge clk); check("R10", {39'd0, cond_flag}, 40'd1);
    model_flag = 1'b1;
    // R2 carry / borrow
    apply("R2", 40'hFF_FFFF_FFFF, 40'd1, 1'b0, 3'd0, 1'b1);
    apply("R2", 40'd5, 40'd5, 1'b1, 3'd0, 1'b1);
    apply("R2", 40'd4, 40'd5, 1'b1, 3'd0, 1'b1);
    // R3 sign
    apply("R3", 40'hC0_0000_0000, 40'd1, 1'b0, 3'd1, 1'b1);
    apply("R3", 40'h30_0080_0000, 40'd1, 1'b0, 3'd1, 1'b1);
    // R4 zero
    apply("R4", 40'h12_3456_789A, 40'h12_3456_789A, 1'b1, 3'd2, 1'b1);
    apply("R4", 40'h00_0000_0001, 40'd0, 1'b1, 3'd2, 1'b1);
    // R5 overflow around guard/main boundary
    apply("R5", 40'hFF_8000_0000, 40'd1, 1'b1, 3'd3, 1'b1);
    apply("R5", 40'hFF_7FFF_FFFF, 40'd1, 1'b0, 3'd3, 1'b1);
    apply("R5", 40'h00_7FFF_FFFF, 40'd1, 1'b0, 3'd3, 1'b1);
    apply("R5", 40'h00_7FFF_FFFE, 40'd1, 1'b0, 3'd3, 1'b1);
    // R6 / R7
    apply("R6", 40'd0, 40'd0, 1'b0, 3'd4, 1'b1);
    apply("R6", 40'd3, 40'd2, 1'b1, 3'd4, 1'b1);
    apply("R7", 40'd0, 40'd0, 1'b0, 3'd5, 1'b1);
    apply("R7", 40'd2, 40'd3, 1'b1, 3'd5, 1'b1);
    // R8 reserved codes hold (flag now 0, operands would set it)
    apply("R8", 40'hFF_FFFF_FFFF, 40'd1, 1'b0, 3'd6, 1'b1);
    apply("R8", 40'd0, 40'd0, 1'b0, 3'd1, 1'b1);
    apply("R8", 40'hFF_0000_0000, 40'd0, 1'b0, 3'd7, 1'b1);
    // R9 strobe low holds
    apply("R9", 40'd0, 40'd0, 1'b0, 3'd2, 1'b0);
    apply("R9", 40'd0, 40'd0, 1'b0, 3'd2, 1'b1);
    apply("R9", 40'd7, 40'd0, 1'b0, 3'd2, 1'b0);
    // random mix across all codes
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      ra = {$urandom(), $urandom()};
      rb = {$urandom(), $urandom()};
      if (i % 4 == 0) ra = {{9{ra[39]}}, ra[30:0]};
      if (i % 5 == 0) rb = ra;
      apply("R1 random", ra, rb, 1'($urandom()), 3'($urandom()), ($urandom() % 4) != 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule